// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is the slave side of a two-wire serial bus, placed in front of a small byte-addressed memory array that is modelled behaviourally. The slave samples the clock and data lines into the system clock domain. It finds start and stop conditions and decodes the slave address byte, which must carry a fixed device identifier and the value on the select pins. It accepts single-byte writes, serves reads byte after byte from an internal address pointer, and answers with acknowledge bits. The data line is driven only through an open-drain pull-low enable.

A write is not applied to the array when its data byte arrives. It is held until the master sends a stop. At that stop the byte is stored and a busy period of a set number of system clocks begins, standing in for the nonvolatile programming time. While busy, the slave ignores the bus and refuses its own address. Word addresses inside a configurable protected window are refused, and the transfer they belong to is abandoned.

A typical use is a configuration store behind a chip's serial management port. The master writes a word address and one data byte and then sends a stop. To read, it sets the pointer with a write header, sends a repeated start and a read header, and then clocks out bytes, acknowledging every one except the last.

Top module: `twowire_nvm_slave`

## Requirements
- R1: While reset is asserted and directly after it is released, `sda_pull_o` is low and the slave is idle and not busy.
- R2: A start is a falling SDA edge while SCL is high, and a stop is a rising SDA edge while SCL is high. Bytes clocked without a preceding start get no acknowledge, and a stop always returns the slave to idle with SDA released.
- R3: The slave address byte is bits [7:4] = identifier (default 4'b1010), bits [3:1] = `sel_i`, and bit [0] = direction (0 write, 1 read). A matching byte is acknowledged by pulling SDA low during the ninth clock.
- R4: An address byte whose identifier or select field does not match gets no acknowledge, and the slave ignores the bus until the next start.
- R5: A write transfer (address byte, word address, one data byte) receives an acknowledge after each of its three bytes.
- R6: A written byte reaches the array only at the stop that ends its transfer. A repeated start before that stop discards it, and no busy period follows.
- R7: For BUSY_CYCLES system clocks after a committing stop, the slave is busy. It leaves SDA released and does not acknowledge its address.
- R8: A word address in the inclusive range PROT_LO..PROT_HI (default 0xC0..0xDF) gets no acknowledge. The rest of that transfer is ignored, the array is not written and no busy period starts. The addresses 0xBF and 0xE0 are accepted.
- R9: A read returns the byte at the address pointer, most significant bit first. The pointer can be set by a write header followed by a repeated start.
- R10: After each byte it sends, the slave samples the ninth bit. A low bit (acknowledge) makes it send the next byte. A high bit makes it release SDA and send nothing more until a start or stop.
- R11: The address pointer advances by one after every byte read or written, wraps from the last address to 0, and keeps its value across transfers.
- R12: A start in the middle of a transfer (repeated start) clears the bit count and restarts address byte decoding.
- R13: The slave changes `sda_pull_o` only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, sampled |
| sda_i | input | 1 | Serial data line, sampled |
| sel_i | input | SEL_W | Select pins compared with address bits [3:1] |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The main function is driven with several kinds of pattern: clean byte writes, random reads that set the pointer through a repeated start, multi-byte sequential reads ended by a master non-acknowledge, and current-address reads after a stop. These separate a correct pointer advance from a stale or doubled one. Address bytes with a wrong identifier and with wrong select bits test the two halves of the match on their own. A header sent straight after a committing stop exposes the busy window. Protected-window probes at 0xBF, 0xC0, 0xDF and 0xE0 pin down both bounds. A write cut short by a repeated start tells a commit at the stop apart from a commit at the data byte, and a read across 0xFF to 0x00 checks the wrap.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_WORDADDR,
        ST_WRDATA,
        ST_RDDATA
    } twm_state_e;

endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_sh_d, scl_sh_q;
    logic [STAGES-1:0] sda_sh_d, sda_sh_q;
    logic              scl_prev_d, scl_prev_q;
    logic              sda_prev_d, sda_prev_q;

    always_comb begin
        scl_sh_d   = {scl_sh_q[STAGES-2:0], scl_i};
        sda_sh_d   = {sda_sh_q[STAGES-2:0], sda_i};
        scl_prev_d = scl_sh_q[STAGES-1];
        sda_prev_d = sda_sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= scl_sh_d;
            sda_sh_q   <= sda_sh_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_lvl   = scl_sh_q[STAGES-1];
    assign sda_lvl   = sda_sh_q[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev_q;
    assign scl_fall  = ~scl_lvl & scl_prev_q;
    assign start_evt = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/twm_busy_timer.sv
module twm_busy_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load_i) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/twm_mem_array.sv
module twm_mem_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[raddr_i];

endmodule

// File: rtl/twowire_nvm_slave.sv
module twowire_nvm_slave #(
    parameter int         ADDR_W      = 8,
    parameter int         SEL_W       = 3,
    parameter logic [7:0] DEV_ID      = 8'h0A,
    parameter int         PROT_LO     = 'hC0,
    parameter int         PROT_HI     = 'hDF,
    parameter int         BUSY_CYCLES = 2000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sda_pull_o
);

    import twm_pkg::*;

    localparam int              ID_W = BYTE_W - 1 - SEL_W;
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(PROT_LO);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(PROT_HI);

    typedef struct packed {
        twm_state_e        st;
        twm_state_e        nxt;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              pull;
        logic              mack;
        logic              pend;
        logic [ADDR_W-1:0] wa;
        logic [BYTE_W-1:0] wd;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
    logic              start_evt, stop_evt;
    logic              busy, busy_load, mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_rdata;
    logic              id_match;
    logic              addr_prot;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twm_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (busy_load),
        .busy_o (busy)
    );

    twm_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (ctl_q.wd),
        .raddr_i (ctl_q.ptr),
        .rdata_o (mem_rdata)
    );

    assign mem_waddr = ctl_q.wa;
    assign id_match  = (ctl_q.sh[BYTE_W-1 -: ID_W] == DEV_ID[ID_W-1:0])
                     && (ctl_q.sh[SEL_W:1] == sel_i);
    assign addr_prot = (ctl_q.sh[ADDR_W-1:0] >= LO_A) && (ctl_q.sh[ADDR_W-1:0] <= HI_A);

    always_comb begin
        ctl_d     = ctl_q;
        mem_we    = 1'b0;
        busy_load = 1'b0;
        if (busy) begin
            // internal write running: bus is not observed at all
            ctl_d.st   = ST_IDLE;
            ctl_d.cnt  = '0;
            ctl_d.pull = 1'b0;
        end else if (stop_evt) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.cnt  = '0;
            ctl_d.pull = 1'b0;
            if (ctl_q.pend) begin
                mem_we     = 1'b1;
                busy_load  = 1'b1;
                ctl_d.pend = 1'b0;
            end
        end else if (start_evt) begin
            ctl_d.st   = ST_DEVADDR;
            ctl_d.cnt  = '0;
            ctl_d.pull = 1'b0;
            ctl_d.pend = 1'b0;
        end else if (ctl_q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (ctl_q.cnt < 4'd8) begin
                    ctl_d.cnt = ctl_q.cnt + 4'd1;
                    if (ctl_q.st != ST_RDDATA) begin
                        ctl_d.sh = {ctl_q.sh[BYTE_W-2:0], sda_lvl};
                    end
                end else if (ctl_q.cnt == 4'd9) begin
                    ctl_d.cnt  = 4'd10;
                    ctl_d.mack = ~sda_lvl;
                end
            end else if (scl_fall) begin
                if (ctl_q.st == ST_RDDATA && ctl_q.cnt >= 4'd1 && ctl_q.cnt <= 4'd7) begin
                    ctl_d.sh   = {ctl_q.sh[BYTE_W-2:0], 1'b0};
                    ctl_d.pull = ~ctl_q.sh[BYTE_W-2];
                end else if (ctl_q.cnt == 4'd8) begin
                    ctl_d.cnt  = 4'd9;
                    ctl_d.pull = 1'b0;
                    ctl_d.nxt  = ST_IDLE;
                    unique case (ctl_q.st)
                        ST_DEVADDR: begin
                            if (id_match) begin
                                ctl_d.pull = 1'b1;
                                ctl_d.nxt  = ctl_q.sh[0] ? ST_RDDATA : ST_WORDADDR;
                            end
                        end
                        ST_WORDADDR: begin
                            if (!addr_prot) begin
                                ctl_d.pull = 1'b1;
                                ctl_d.ptr  = ctl_q.sh[ADDR_W-1:0];
                                ctl_d.nxt  = ST_WRDATA;
                            end
                        end
                        ST_WRDATA: begin
                            ctl_d.pull = 1'b1;
                            ctl_d.pend = 1'b1;
                            ctl_d.wa   = ctl_q.ptr;
                            ctl_d.wd   = ctl_q.sh;
                            ctl_d.ptr  = ctl_q.ptr + ADDR_W'(1);
                        end
                        default: ctl_d.pull = 1'b0;
                    endcase
                end else if (ctl_q.cnt == 4'd10) begin
                    ctl_d.cnt  = '0;
                    ctl_d.pull = 1'b0;
                    if (ctl_q.st == ST_RDDATA) begin
                        if (ctl_q.mack) begin
                            ctl_d.sh   = mem_rdata;
                            ctl_d.pull = ~mem_rdata[BYTE_W-1];
                            ctl_d.ptr  = ctl_q.ptr + ADDR_W'(1);
                        end else begin
                            ctl_d.st = ST_IDLE;
                        end
                    end else begin
                        ctl_d.st = ctl_q.nxt;
                        if (ctl_q.nxt == ST_RDDATA) begin
                            ctl_d.sh   = mem_rdata;
                            ctl_d.pull = ~mem_rdata[BYTE_W-1];
                            ctl_d.ptr  = ctl_q.ptr + ADDR_W'(1);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.st   <= ST_IDLE;
            ctl_q.nxt  <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull_o = ctl_q.pull;

endmodule

// File: rtl/twm_checker.sv
module twm_checker #(
    parameter int ADDR_W  = 8,
    parameter int PROT_LO = 'hC0,
    parameter int PROT_HI = 'hDF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_pull_o,
    input logic              scl_lvl,
    input logic              stop_evt,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr
);

    logic waddr_prot;
    assign waddr_prot = (mem_waddr >= ADDR_W'(PROT_LO)) && (mem_waddr <= ADDR_W'(PROT_HI));

    // R13
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_lvl);

    // R7
    busy_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R7
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy);

    // R8
    no_prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !waddr_prot);

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !busy) |=> !sda_pull_o);

endmodule

bind twowire_nvm_slave twm_checker #(
    .ADDR_W  (ADDR_W),
    .PROT_LO (PROT_LO),
    .PROT_HI (PROT_HI)
) u_twm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .scl_lvl    (scl_lvl),
    .stop_evt   (stop_evt),
    .busy       (busy),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr)
);

// File: tb/twowire_nvm_slave_bench.sv
`timescale 1ns/1ps
module twowire_nvm_slave_bench;

    localparam int WAIT_BUSY = 2100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_pull = 1'b0;
    logic [2:0] sel = 3'b101;
    logic       dut_pull;
    logic       sda_bus;
    int         n_chk = 0;
    int         n_fail = 0;
    int         r13_viol = 0;
    logic       done = 1'b0;
    logic       prev_pull = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus = ~(dut_pull | m_pull);

    twowire_nvm_slave u_twowire_nvm_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sel_i      (sel),
        .sda_pull_o (dut_pull)
    );

    // R13 monitor: slave output may only move while the clock line is low
    always @(negedge clk) begin
        if (rst_n && (dut_pull !== prev_pull) && scl) r13_viol++;
        prev_pull = dut_pull;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_pull = 1'b0; hold(4);
        scl = 1'b1;    hold(8);
        m_pull = 1'b1; hold(8);
        scl = 1'b0;    hold(4);
    endtask

    task automatic bus_stop();
        m_pull = 1'b1; hold(4);
        scl = 1'b1;    hold(8);
        m_pull = 1'b0; hold(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_pull = ~b[i]; hold(4);
            scl = 1'b1;     hold(8);
            scl = 1'b0;     hold(4);
        end
        m_pull = 1'b0; hold(4);
        scl = 1'b1;    hold(4);
        ack = ~sda_bus; hold(4);
        scl = 1'b0;    hold(4);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_pull = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hold(4); scl = 1'b1;
            hold(4); b = {b[6:0], sda_bus};
            hold(4); scl = 1'b0;
        end
        hold(4); m_pull = give_ack;
        hold(4); scl = 1'b1;
        hold(8); scl = 1'b0;
        hold(2); m_pull = 1'b0;
    endtask

    function automatic logic [7:0] hdr(input logic [3:0] id, input logic [2:0] s, input logic rd);
        return {id, s, rd};
    endfunction

    task automatic write_txn(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
        logic k;
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k); acks[2] = k;
        send_byte(a, k); acks[1] = k;
        send_byte(d, k); acks[0] = k;
        bus_stop();
    endtask

    task automatic set_ptr_read(input logic [7:0] a, output logic [2:0] acks);
        logic k;
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k); acks[2] = k;
        send_byte(a, k); acks[1] = k;
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b1), k); acks[0] = k;
    endtask

    task automatic t_reset();
        logic k;
        chk("R1 pull during reset", dut_pull, 1'b0);
        hold(4); rst_n = 1'b1; hold(4);
        chk("R1 pull after reset", dut_pull, 1'b0);
        scl = 1'b0; hold(4);
        send_byte(hdr(4'hA, sel, 1'b0), k);
        chk("R2 header without start not acked", k, 1'b0);
        bus_stop();
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        chk("R1 idle, not busy after reset (R3 header acked)", k, 1'b1);
        bus_stop();
        chk("R2 stop releases SDA", dut_pull, 1'b0);
    endtask

    task automatic t_write_busy_read();
        logic [2:0] a;
        logic       k;
        logic [7:0] b;
        write_txn(8'h10, 8'h5A, a);
        chk("R5 write acks", a, 3'b111);
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        chk("R7 header refused while busy", k, 1'b0);
        bus_stop();
        hold(WAIT_BUSY);
        set_ptr_read(8'h10, a);
        chk("R12 repeated start header acked", a, 3'b111);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R9 read back 0x10", b, 8'h5A);
    endtask

    task automatic t_mismatch();
        logic k;
        bus_start();
        send_byte(hdr(4'hB, sel, 1'b0), k);
        chk("R4 wrong identifier", k, 1'b0);
        send_byte(8'h00, k);
        chk("R4 following byte ignored", k, 1'b0);
        bus_stop();
        bus_start();
        send_byte(hdr(4'hA, sel ^ 3'b001, 1'b0), k);
        chk("R4 wrong select", k, 1'b0);
        bus_stop();
    endtask

    task automatic t_seq_read();
        logic [2:0] a;
        logic [7:0] b;
        logic       k;
        write_txn(8'h20, 8'h11, a); hold(WAIT_BUSY);
        write_txn(8'h21, 8'h22, a); hold(WAIT_BUSY);
        write_txn(8'h22, 8'h33, a); hold(WAIT_BUSY);
        set_ptr_read(8'h20, a);
        recv_byte(1'b1, b);
        chk("R9 first sequential byte", b, 8'h11);
        recv_byte(1'b0, b);
        chk("R10 acked master gets next byte", b, 8'h22);
        recv_byte(1'b0, b);
        chk("R10 silent after master nack", b, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b1), k);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R11 pointer kept across transfers", b, 8'h33);
    endtask

    task automatic probe_addr(input logic [7:0] a, output logic k);
        logic h;
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), h);
        send_byte(a, k);
        bus_stop();
    endtask

    task automatic t_protect();
        logic k;
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        send_byte(8'hC4, k);
        chk("R8 protected word address refused", k, 1'b0);
        send_byte(8'hEE, k);
        chk("R8 data after refusal ignored", k, 1'b0);
        bus_stop();
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        chk("R8 no busy after refused write", k, 1'b1);
        bus_stop();
        probe_addr(8'hBF, k); chk("R8 0xBF accepted", k, 1'b1);
        probe_addr(8'hC0, k); chk("R8 0xC0 refused", k, 1'b0);
        probe_addr(8'hDF, k); chk("R8 0xDF refused", k, 1'b0);
        probe_addr(8'hE0, k); chk("R8 0xE0 accepted", k, 1'b1);
    endtask

    task automatic t_abort();
        logic [2:0] a;
        logic       k;
        logic [7:0] b;
        write_txn(8'h30, 8'h44, a); hold(WAIT_BUSY);
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        send_byte(8'h30, k);
        send_byte(8'h99, k);
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        bus_stop();
        bus_start();
        send_byte(hdr(4'hA, sel, 1'b0), k);
        chk("R6 no busy after discarded write", k, 1'b1);
        bus_stop();
        set_ptr_read(8'h30, a);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R6 array unchanged by discarded write", b, 8'h44);
    endtask

    task automatic t_wrap();
        logic [2:0] a;
        logic [7:0] b0, b1;
        write_txn(8'hFF, 8'hA1, a); hold(WAIT_BUSY);
        write_txn(8'h00, 8'hB2, a); hold(WAIT_BUSY);
        set_ptr_read(8'hFF, a);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
        chk("R11 byte at last address", b0, 8'hA1);
        chk("R11 wrap to address 0", b1, 8'hB2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        hold(2);
        t_reset();
        t_write_busy_read();
        t_mismatch();
        t_seq_read();
        t_protect();
        t_abort();
        t_wrap();
        chk("R13 SDA moved while SCL high", r13_viol, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule